// File: doc/BRIEF.md
# Clos Middle-Stage Assignment by Recursive Euler Splitting

This block assigns a middle-stage switch to every connection of a three-stage Clos fabric whose middle stage has as many switches as each edge switch has ports. A full port-to-port permutation is loaded with a start pulse. Each connection is treated as an edge between its first-stage switch and its third-stage switch. The result is a bipartite multigraph in which every vertex has degree `N_SW`. A proper edge coloring of this graph gives every connection a middle switch, and no middle switch is used twice at the same edge switch.

The engine runs `log2(N_SW)` rounds. In each round it walks closed trails through every current subgraph, one edge per clock. It sends alternate edges of each trail to the two halves and records the choice as one bit of a per-connection label. Subgraphs are identified by the label bits settled in earlier rounds. After the last round every subgraph has degree one, and the full label is the middle-switch index. A `done` flag then holds the result until the next start. `N_SW` must be a power of two of at least 2, and the permutation must be complete.

Top module: `clos_edge_colorer`

## Requirements
- R1: After reset, `done_o` is 0 and every color field of `color_o` is 0.
- R2: A `start_i` pulse while idle latches `perm_i`, and `done_o` is 0 on the following cycle.
- R3: When `done_o` is 1, no two connections whose input ports share a first-stage switch (input port divided by `N_SW`) carry the same color. Connection p's color is `color_o[p*log2(N_SW) +: log2(N_SW)]`.
- R4: When `done_o` is 1, no two connections whose destinations share a third-stage switch (`perm_i` entry divided by `N_SW`) carry the same color. Input port p's destination is `perm_i[p*log2(N_SW*M_SW) +: log2(N_SW*M_SW)]`.
- R5: While idle with `done_o` at 1 and no start, `done_o` stays 1 and `color_o` stays unchanged, whatever `perm_i` does.
- R6: `done_o` rises at most log2(N_SW)*(2*N_SW*M_SW+1)+2 cycles after the start pulse.
- R7: `start_i` and changes on `perm_i` while a run is in progress are ignored. The run completes with a valid coloring of the permutation latched at its start.
- R8: The same permutation always yields the same colors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled only while idle |
| perm_i | input | N_SW*M_SW*log2(N_SW*M_SW) | Destination port for each input port, packed by input port |
| color_o | output | N_SW*M_SW*log2(N_SW) | Middle-switch index per connection, packed by input port |
| done_o | output | 1 | All rounds finished, result valid |

## Verification
Two instances share the stimulus: one with four ports per edge switch and four edge switches, which needs two split rounds, and one with eight ports per edge switch and two edge switches, which needs three rounds. Both have 16 ports, so the same permutation drives both. The two-switch instance carries many parallel edges between the same vertex pair. The identity permutation produces one switch pair per port group. Together these cases exercise trails that revisit a vertex and a recursion depth beyond two.

// File: rtl/clos_color_pkg.sv
package clos_color_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEEK = 2'd1,
        PH_WALK = 2'd2
    } phase_e;

    function automatic int bits_for(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/clos_vertex_map.sv
module clos_vertex_map #(
    parameter int N_SW = 4,
    parameter int M_SW = 4
) (
    input  logic [N_SW*M_SW*clos_color_pkg::bits_for(N_SW*M_SW)-1:0] perm_i,
    output logic [N_SW*M_SW-1:0][clos_color_pkg::bits_for(M_SW)-1:0] left_v_o,
    output logic [N_SW*M_SW-1:0][clos_color_pkg::bits_for(M_SW)-1:0] right_v_o
);
    localparam int NE = N_SW * M_SW;
    localparam int PW = clos_color_pkg::bits_for(NE);
    localparam int CW = clos_color_pkg::bits_for(N_SW);
    localparam int VW = clos_color_pkg::bits_for(M_SW);

    for (genvar e = 0; e < NE; e++) begin : g_edge
        logic [PW-1:0] dest_port;
        logic [PW-1:0] dest_sw;
        assign dest_port       = perm_i[e*PW +: PW];
        assign dest_sw         = dest_port >> CW;
        assign right_v_o[e]    = VW'(dest_sw);
        assign left_v_o[e]     = VW'(e / N_SW);
    end
endmodule

// File: rtl/clos_candidate_match.sv
module clos_candidate_match #(
    parameter int NE = 16,
    parameter int CW = 2,
    parameter int VW = 2
) (
    input  logic [NE-1:0]         used_i,
    input  logic [NE-1:0][CW-1:0] label_i,
    input  logic [NE-1:0][VW-1:0] left_v_i,
    input  logic [NE-1:0][VW-1:0] right_v_i,
    input  logic [VW-1:0]         cur_v_i,
    input  logic                  cur_right_i,
    input  logic [CW-1:0]         prefix_i,
    input  logic [CW-1:0]         mask_i,
    output logic [NE-1:0]         walk_req_o,
    output logic [NE-1:0]         seek_req_o
);
    for (genvar e = 0; e < NE; e++) begin : g_cand
        logic at_vertex;
        logic same_sub;
        assign at_vertex     = cur_right_i ? (right_v_i[e] == cur_v_i)
                                           : (left_v_i[e] == cur_v_i);
        assign same_sub      = ((label_i[e] ^ prefix_i) & mask_i) == '0;
        assign walk_req_o[e] = !used_i[e] && at_vertex && same_sub;
        assign seek_req_o[e] = !used_i[e];
    end
endmodule

// File: rtl/clos_lowest_pick.sv
module clos_lowest_pick #(
    parameter int W = 16
) (
    input  logic [W-1:0]                              req_i,
    output logic                                      found_o,
    output logic [clos_color_pkg::bits_for(W)-1:0]    idx_o
);
    localparam int IW = clos_color_pkg::bits_for(W);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/clos_edge_colorer.sv
module clos_edge_colorer
    import clos_color_pkg::*;
#(
    parameter int N_SW = 4,
    parameter int M_SW = 4
) (
    input  logic                                               clk,
    input  logic                                               rst_n,
    input  logic                                               start_i,
    input  logic [N_SW*M_SW*clos_color_pkg::bits_for(N_SW*M_SW)-1:0] perm_i,
    output logic [N_SW*M_SW*clos_color_pkg::bits_for(N_SW)-1:0]      color_o,
    output logic                                               done_o
);
    localparam int NE   = N_SW * M_SW;
    localparam int CW   = bits_for(N_SW);
    localparam int VW   = bits_for(M_SW);
    localparam int IW   = bits_for(NE);
    localparam logic [CW-1:0] LAST_ROUND = CW'($clog2(N_SW) - 1);

    typedef struct packed {
        phase_e                phase;
        logic [CW-1:0]         round;
        logic [NE-1:0]         used;
        logic [NE-1:0][CW-1:0] label;
        logic [NE-1:0][VW-1:0] rv;
        logic [VW-1:0]         cur;
        logic                  side;
        logic                  parity;
        logic [CW-1:0]         prefix;
        logic                  done;
    } state_t;

    state_t s_q, s_d;

    logic [NE-1:0][VW-1:0] map_lv, map_rv;
    logic [NE-1:0]         walk_req, seek_req;
    logic                  walk_found, seek_found;
    logic [IW-1:0]         walk_idx, seek_idx;
    logic [CW-1:0]         sub_mask;

    assign sub_mask = (CW'(1) << s_q.round) - CW'(1);

    clos_vertex_map #(.N_SW(N_SW), .M_SW(M_SW)) u_map (
        .perm_i    (perm_i),
        .left_v_o  (map_lv),
        .right_v_o (map_rv)
    );

    clos_candidate_match #(.NE(NE), .CW(CW), .VW(VW)) u_match (
        .used_i      (s_q.used),
        .label_i     (s_q.label),
        .left_v_i    (map_lv),
        .right_v_i   (s_q.rv),
        .cur_v_i     (s_q.cur),
        .cur_right_i (s_q.side),
        .prefix_i    (s_q.prefix),
        .mask_i      (sub_mask),
        .walk_req_o  (walk_req),
        .seek_req_o  (seek_req)
    );

    clos_lowest_pick #(.W(NE)) u_pick_walk (
        .req_i   (walk_req),
        .found_o (walk_found),
        .idx_o   (walk_idx)
    );

    clos_lowest_pick #(.W(NE)) u_pick_seek (
        .req_i   (seek_req),
        .found_o (seek_found),
        .idx_o   (seek_idx)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase  = PH_SEEK;
                    s_d.round  = '0;
                    s_d.used   = '0;
                    s_d.label  = '0;
                    s_d.rv     = map_rv;
                    s_d.side   = 1'b0;
                    s_d.parity = 1'b0;
                    s_d.done   = 1'b0;
                end
            end
            PH_SEEK: begin
                if (seek_found) begin
                    s_d.used[seek_idx]           = 1'b1;
                    s_d.label[seek_idx][s_q.round] = 1'b0;
                    s_d.prefix                   = s_q.label[seek_idx];
                    s_d.cur                      = s_q.rv[seek_idx];
                    s_d.side                     = 1'b1;
                    s_d.parity                   = 1'b1;
                    s_d.phase                    = PH_WALK;
                end else if (s_q.round == LAST_ROUND) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.round = s_q.round + CW'(1);
                    s_d.used  = '0;
                end
            end
            PH_WALK: begin
                if (walk_found) begin
                    s_d.used[walk_idx]             = 1'b1;
                    s_d.label[walk_idx][s_q.round] = s_q.parity;
                    s_d.cur    = s_q.side ? map_lv[walk_idx] : s_q.rv[walk_idx];
                    s_d.side   = ~s_q.side;
                    s_d.parity = ~s_q.parity;
                end else begin
                    s_d.phase = PH_SEEK;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign color_o = s_q.label;
    assign done_o  = s_q.done;

    // R2
    start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && s_q.phase == PH_IDLE) |=> (!done_o && s_q.phase == PH_SEEK));

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(color_o)));

    // R3
    trail_closes_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_WALK && !walk_found) |-> (!s_q.parity && !s_q.side));

    // R7
    busy_ignores_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE) |=> $stable(s_q.rv));

    // R6
    round_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE) |-> (s_q.round <= LAST_ROUND));

    // R4
    walk_edge_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_WALK && walk_found) |=> $countones(s_q.used) == $countones($past(s_q.used)) + 1);
endmodule

// File: tb/clos_edge_colorer_tb.sv
module clos_edge_colorer_tb;
    localparam int NP  = 16;
    localparam int PW  = 4;
    localparam int NA  = 4;
    localparam int MA  = 4;
    localparam int CWA = 2;
    localparam int NB  = 8;
    localparam int MB  = 2;
    localparam int CWB = 3;

    typedef int perm_t [NP];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NP*PW-1:0]  perm = '0;
    logic [NP*CWA-1:0] color_a;
    logic [NP*CWB-1:0] color_b;
    logic done_a, done_b;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    clos_edge_colorer #(.N_SW(NA), .M_SW(MA)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .perm_i(perm),
        .color_o(color_a), .done_o(done_a)
    );

    clos_edge_colorer #(.N_SW(NB), .M_SW(MB)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .start_i(start), .perm_i(perm),
        .color_o(color_b), .done_o(done_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clash_count(input perm_t pa, input perm_t col, input int n, input bit third);
        int bad = 0;
        for (int p = 0; p < NP; p++) begin
            for (int q = p + 1; q < NP; q++) begin
                int kp;
                int kq;
                kp = third ? pa[p] / n : p / n;
                kq = third ? pa[q] / n : q / n;
                if (kp == kq && col[p] == col[q]) bad++;
            end
        end
        return bad;
    endfunction

    function automatic perm_t cols_a();
        perm_t c;
        for (int e = 0; e < NP; e++) c[e] = int'(color_a[e*CWA +: CWA]);
        return c;
    endfunction

    function automatic perm_t cols_b();
        perm_t c;
        for (int e = 0; e < NP; e++) c[e] = int'(color_b[e*CWB +: CWB]);
        return c;
    endfunction

    task automatic put_perm(input perm_t pa);
        for (int e = 0; e < NP; e++) perm[e*PW +: PW] = PW'(pa[e]);
    endtask

    task automatic launch(input perm_t pa);
        put_perm(pa);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: done cleared one cycle after the start pulse
        chk(!done_a, "R2 done low after start (A)", int'(done_a), 0);
        chk(!done_b, "R2 done low after start (B)", int'(done_b), 0);
    endtask

    task automatic wait_done(output int ca, output int cb);
        int cnt;
        cnt = 1;
        ca = 0;
        cb = 0;
        while ((ca == 0 || cb == 0) && cnt < 3000) begin
            if (done_a && ca == 0) ca = cnt;
            if (done_b && cb == 0) cb = cnt;
            if (ca == 0 || cb == 0) begin
                @(negedge clk);
                cnt++;
            end
        end
    endtask

    task automatic verify(input perm_t pa, input int ca, input int cb);
        perm_t ka;
        perm_t kb;
        int bnd_a;
        int bnd_b;
        bnd_a = 2 * (2 * NP + 1) + 2;
        bnd_b = 3 * (2 * NP + 1) + 2;
        // R6: completion within the round bound (0 means the wait timed out)
        chk(ca > 0 && ca <= bnd_a, "R6 cycles to done (A)", ca, bnd_a);
        chk(cb > 0 && cb <= bnd_b, "R6 cycles to done (B)", cb, bnd_b);
        ka = cols_a();
        kb = cols_b();
        chk(clash_count(pa, ka, NA, 1'b0) == 0, "R3 first-stage clash (A)", clash_count(pa, ka, NA, 1'b0), 0);
        chk(clash_count(pa, kb, NB, 1'b0) == 0, "R3 first-stage clash (B)", clash_count(pa, kb, NB, 1'b0), 0);
        chk(clash_count(pa, ka, NA, 1'b1) == 0, "R4 third-stage clash (A)", clash_count(pa, ka, NA, 1'b1), 0);
        chk(clash_count(pa, kb, NB, 1'b1) == 0, "R4 third-stage clash (B)", clash_count(pa, kb, NB, 1'b1), 0);
    endtask

    task automatic shuffle(output perm_t pa);
        for (int i = 0; i < NP; i++) pa[i] = i;
        for (int i = NP - 1; i > 0; i--) begin
            int j;
            int t;
            j = int'($urandom_range(i, 0));
            t = pa[i];
            pa[i] = pa[j];
            pa[j] = t;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        perm_t pa;
        perm_t pb;
        perm_t ra;
        perm_t rb;
        int ca;
        int cb;
        void'($urandom(32'h5EED));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!done_a && !done_b, "R1 done low after reset", int'(done_a) + int'(done_b), 0);
        chk(color_a == '0 && color_b == '0, "R1 colors zero after reset",
            int'(color_a != '0) + int'(color_b != '0), 0);

        // identity permutation
        for (int i = 0; i < NP; i++) pa[i] = i;
        launch(pa);
        wait_done(ca, cb);
        verify(pa, ca, cb);

        // reversal permutation
        for (int i = 0; i < NP; i++) pa[i] = NP - 1 - i;
        launch(pa);
        wait_done(ca, cb);
        verify(pa, ca, cb);

        // R5: result holds while idle even as perm_i wanders
        ra = cols_a();
        rb = cols_b();
        for (int k = 0; k < 6; k++) begin
            perm = {$urandom, $urandom};
            @(negedge clk);
        end
        chk(done_a && done_b, "R5 done held", int'(done_a) + int'(done_b), 2);
        chk(cols_a() == ra && cols_b() == rb, "R5 colors held",
            int'(cols_a() != ra) + int'(cols_b() != rb), 0);

        // R7: start and perm changes during a run are ignored
        shuffle(pa);
        shuffle(pb);
        launch(pa);
        repeat (3) @(negedge clk);
        put_perm(pb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ca, cb);
        ca = ca + 4;
        cb = cb + 4;
        // R7: coloring must be valid for the permutation latched first
        verify(pa, ca, cb);
        ra = cols_a();
        rb = cols_b();

        // R8: rerun of the same permutation repeats the colors
        launch(pa);
        wait_done(ca, cb);
        chk(cols_a() == ra, "R8 repeatable colors (A)", int'(cols_a() != ra), 0);
        chk(cols_b() == rb, "R8 repeatable colors (B)", int'(cols_b() != rb), 0);

        // random permutations
        for (int t = 0; t < 30; t++) begin
            shuffle(pa);
            launch(pa);
            wait_done(ca, cb);
            verify(pa, ca, cb);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule